// File: doc/BRIEF.md
# Memory-Resident Pending Bitmap Engine

This block keeps the pending state of message-signalled interrupts, which lives as bitmaps in system memory with one bit per interrupt ID. It reaches that memory through a byte-wide read/write port and changes it only by read-modify-write. One command at a time arrives on a valid/ready port. A command sets or clears one ID's bit. It can also move one ID's pending state from a source bitmap to a destination bitmap. A third command merges the whole source bitmap into the destination and empties the source.

Each command carries the settings of two tables, a source side and a destination side. Per side these are an enable, an ID-width field, a table base byte address and the ID that a separate scanner currently ranks best on that side. The block does no priority evaluation. It tells the scanner which follow-up is needed. A `cand_valid` pulse offers a single newly pending ID for an incremental comparison. A `rescan_src` or `rescan_dst` pulse asks for a full rescan of that side's table.

A set/clear command always acts on the destination side. The block skips any write that would not change memory. It only calls for a full rescan when the cleared ID is the one the scanner holds as best.

Top module: `pend_table_engine`

## Requirements
- R1: After reset `cmd_ready` is 1, and `busy`, `mem_rd_en`, `mem_wr_en`, `cand_valid`, `rescan_src` and `rescan_dst` are 0.
- R2: A set/clear command (`cmd_op` = 0) makes no memory access and produces no pulse in any of these cases: `dst_en` is 0, the ID is below `FIRST_ID` (8192), or the ID is above 2^(w+1)−1. Here w is `dst_idbits` clamped to at most `ID_W`−1 (15).
- R3: A set/clear that is not ignored reads byte `dst_base` + ID/8 and compares bit ID%8 with `cmd_level`. If they are equal, nothing is written. Otherwise that byte is written back with only that bit replaced by `cmd_level`.
- R4: When a write sets a bit on the destination, `cand_valid` pulses for one cycle with `cand_id` equal to the ID, one cycle after the write. No rescan pulse is given.
- R5: When a write clears a bit and the ID equals `dst_best`, `rescan_dst` pulses one cycle after the write. Clearing any other ID gives no pulse.
- R6: A single move (`cmd_op` = 1) or a move-all (`cmd_op` = 2) makes no memory access and gives no pulse unless both `src_en` and `dst_en` are 1.
- R7: For both moves, w is the smaller of the two clamped ID widths. A single move whose ID is above 2^(w+1)−1 is a no-op.
- R8: A single move reads byte `src_base` + ID/8. If bit ID%8 is 0, it stops there. Otherwise it writes that byte with the bit cleared. If the ID equals `src_best`, `rescan_src` pulses in the cycle after that write. The move then performs a set of the ID on the destination, with the behaviour of R3 and R4.
- R9: A move-all visits byte indices from `FIRST_ID`/8 (1024) to 2^(w+1)/8−1 in ascending order and reads the source byte at each. A zero byte causes no other access. For a nonzero byte, the block reads the destination byte, writes destination OR source to it, and then writes 0 to the source byte.
- R10: When a move-all ends, `rescan_src` and `rescan_dst` pulse together in the cycle after the last access. If the index range is empty, they pulse in the cycle after acceptance.
- R11: A command is taken when `cmd_valid` and `cmd_ready` are both 1. `cmd_ready` is the inverse of `busy`. `busy` is 1 from the cycle after a command that needs memory is accepted until the final access of that command has been issued. Opcode 3 is accepted and ignored.
- R12: A read returns `mem_rdata` one cycle after `mem_rd_en`. Reads and writes never occur in the same cycle. Every write follows a read two cycles earlier or a write one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Engine idle, command taken this cycle |
| cmd_op | input | 2 | 0 set/clear, 1 move one ID, 2 move all, 3 ignored |
| cmd_id | input | ID_W | Interrupt ID for set/clear and single move |
| cmd_level | input | 1 | Requested bit value for set/clear |
| src_en | input | 1 | Source side enabled |
| src_idbits | input | IDB_W | Source ID-width field |
| src_base | input | ADDR_W | Source bitmap byte base |
| src_best | input | ID_W | Scanner's current best ID on the source side |
| dst_en | input | 1 | Destination side enabled |
| dst_idbits | input | IDB_W | Destination ID-width field |
| dst_base | input | ADDR_W | Destination bitmap byte base |
| dst_best | input | ID_W | Scanner's current best ID on the destination side |
| busy | output | 1 | Command in progress |
| mem_rd_en | output | 1 | Byte read request |
| mem_wr_en | output | 1 | Byte write request |
| mem_addr | output | ADDR_W | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, one cycle after the request |
| cand_valid | output | 1 | Offer one ID for incremental comparison |
| cand_id | output | ID_W | The offered ID |
| rescan_src | output | 1 | Full rescan of the source table needed |
| rescan_dst | output | 1 | Full rescan of the destination table needed |

## Verification
A wrong byte index, base selection or bit position shows at the ports on the first write of a command: the address or data differs from the one predicted from a shadow copy of memory. The memory contents also diverge, and a full comparison after every command catches that. A wrong admission decision or a wrong walk bound appears as a different read count, or as `busy` not rising, in the cycle after acceptance. A lost best-ID comparison, or a latched level that is wrong, shows as a missing or extra notification pulse within one cycle of the final write.

// File: rtl/pend_pkg.sv
package pend_pkg;

    typedef enum logic [1:0] {
        OP_SETCLR  = 2'd0,
        OP_MOVE    = 2'd1,
        OP_MOVEALL = 2'd2,
        OP_RSVD    = 2'd3
    } pend_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SRC_RD,
        ST_SRC_CHK,
        ST_SRC_WR,
        ST_DST_RD,
        ST_DST_CHK,
        ST_DST_WR
    } pend_st_e;

    // where an admitted command starts
    typedef enum logic [1:0] {
        GO_NONE,
        GO_SRC,
        GO_DST,
        GO_EMPTY
    } pend_go_e;

    function automatic logic [7:0] bit_put(logic [7:0] b, logic [2:0] pos, logic lvl);
        logic [7:0] r;
        r      = b;
        r[pos] = lvl;
        return r;
    endfunction

endpackage

// File: rtl/pend_cmd_gate.sv
module pend_cmd_gate
    import pend_pkg::*;
#(
    parameter int ID_W     = 16,
    parameter int IDB_W    = 5,
    parameter int FIRST_ID = 8192,
    localparam int BYTE_W  = ID_W - 3
) (
    input  pend_op_e          op,
    input  logic [ID_W-1:0]   id,
    input  logic              src_en,
    input  logic [IDB_W-1:0]  src_idbits,
    input  logic              dst_en,
    input  logic [IDB_W-1:0]  dst_idbits,
    output pend_go_e          go,
    output logic [BYTE_W-1:0] last_idx
);
    localparam logic [IDB_W-1:0] W_MAX = IDB_W'(ID_W - 1);
    localparam int WALK_FIRST = FIRST_ID / 8;

    logic [IDB_W-1:0] w_src, w_dst, w_mv;
    logic             fits_dst, fits_mv, both_on, walk_empty;
    logic [ID_W:0]    span, nbytes;

    always_comb begin
        w_src    = (src_idbits > W_MAX) ? W_MAX : src_idbits;
        w_dst    = (dst_idbits > W_MAX) ? W_MAX : dst_idbits;
        w_mv     = (w_src < w_dst) ? w_src : w_dst;
        fits_dst = ((32'(id) >> (32'(w_dst) + 1)) == 32'd0);
        fits_mv  = ((32'(id) >> (32'(w_mv) + 1)) == 32'd0);
        both_on  = src_en && dst_en;
        span       = (ID_W+1)'(1) << (32'(w_mv) + 1);
        nbytes     = span >> 3;
        walk_empty = (32'(nbytes) <= WALK_FIRST);
        last_idx   = BYTE_W'(nbytes - 1'b1);
        unique case (op)
            OP_SETCLR:  go = (dst_en && (32'(id) >= FIRST_ID) && fits_dst) ? GO_DST : GO_NONE;
            OP_MOVE:    go = (both_on && fits_mv) ? GO_SRC : GO_NONE;
            OP_MOVEALL: go = both_on ? (walk_empty ? GO_EMPTY : GO_SRC) : GO_NONE;
            default:    go = GO_NONE;
        endcase
    end

endmodule

// File: rtl/pend_rmw_seq.sv
module pend_rmw_seq
    import pend_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int ID_W     = 16,
    parameter int FIRST_ID = 8192,
    localparam int BYTE_W  = ID_W - 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  pend_op_e          op,
    input  logic [ID_W-1:0]   id,
    input  logic              level,
    input  pend_go_e          go,
    input  logic [BYTE_W-1:0] last_idx,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ID_W-1:0]   src_best,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [ID_W-1:0]   dst_best,
    output logic              busy,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              cand_valid,
    output logic [ID_W-1:0]   cand_id,
    output logic              rescan_src,
    output logic              rescan_dst
);
    localparam logic [BYTE_W-1:0] WALK_FIRST = BYTE_W'(FIRST_ID / 8);

    pend_st_e          st;
    pend_op_e          op_q;
    logic [ID_W-1:0]   id_q, src_best_q, dst_best_q;
    logic              lvl_q;
    logic [ADDR_W-1:0] src_base_q, dst_base_q;
    logic [BYTE_W-1:0] idx, last_q;
    logic [7:0]        keep_q, wbyte_q;
    logic              cand_q, rsrc_q, rdst_q;
    logic              walk, at_last, src_side;
    logic [2:0]        bpos;

    assign walk    = (op_q == OP_MOVEALL);
    assign at_last = (idx == last_q);
    assign bpos    = id_q[2:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= ST_IDLE;
            op_q       <= OP_SETCLR;
            id_q       <= '0;
            lvl_q      <= 1'b0;
            src_base_q <= '0;
            dst_base_q <= '0;
            src_best_q <= '0;
            dst_best_q <= '0;
            idx        <= '0;
            last_q     <= '0;
            keep_q     <= '0;
            wbyte_q    <= '0;
            cand_q     <= 1'b0;
            rsrc_q     <= 1'b0;
            rdst_q     <= 1'b0;
        end else begin
            cand_q <= 1'b0;
            rsrc_q <= 1'b0;
            rdst_q <= 1'b0;
            unique case (st)
                ST_IDLE: if (cmd_valid) begin
                    op_q       <= op;
                    id_q       <= id;
                    lvl_q      <= (op == OP_MOVE) ? 1'b1 : level;
                    src_base_q <= src_base;
                    dst_base_q <= dst_base;
                    src_best_q <= src_best;
                    dst_best_q <= dst_best;
                    last_q     <= last_idx;
                    unique case (go)
                        GO_DST: begin
                            idx <= id[ID_W-1:3];
                            st  <= ST_DST_RD;
                        end
                        GO_SRC: begin
                            idx <= (op == OP_MOVEALL) ? WALK_FIRST : id[ID_W-1:3];
                            st  <= ST_SRC_RD;
                        end
                        GO_EMPTY: begin
                            rsrc_q <= 1'b1;
                            rdst_q <= 1'b1;
                        end
                        default: ;
                    endcase
                end
                ST_SRC_RD: st <= ST_SRC_CHK;
                ST_SRC_CHK: begin
                    if (walk) begin
                        if (mem_rdata == 8'd0) begin
                            if (at_last) begin
                                st     <= ST_IDLE;
                                rsrc_q <= 1'b1;
                                rdst_q <= 1'b1;
                            end else begin
                                idx <= idx + 1'b1;
                                st  <= ST_SRC_RD;
                            end
                        end else begin
                            keep_q <= mem_rdata;
                            st     <= ST_DST_RD;
                        end
                    end else if (mem_rdata[bpos]) begin
                        wbyte_q <= bit_put(mem_rdata, bpos, 1'b0);
                        st      <= ST_SRC_WR;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                ST_SRC_WR: begin
                    if (walk) begin
                        if (at_last) begin
                            st     <= ST_IDLE;
                            rsrc_q <= 1'b1;
                            rdst_q <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                            st  <= ST_SRC_RD;
                        end
                    end else begin
                        if (id_q == src_best_q) rsrc_q <= 1'b1;
                        st <= ST_DST_RD;
                    end
                end
                ST_DST_RD: st <= ST_DST_CHK;
                ST_DST_CHK: begin
                    if (walk) begin
                        wbyte_q <= mem_rdata | keep_q;
                        st      <= ST_DST_WR;
                    end else if (mem_rdata[bpos] == lvl_q) begin
                        st <= ST_IDLE;
                    end else begin
                        wbyte_q <= bit_put(mem_rdata, bpos, lvl_q);
                        st      <= ST_DST_WR;
                    end
                end
                ST_DST_WR: begin
                    if (walk) begin
                        wbyte_q <= 8'd0;
                        st      <= ST_SRC_WR;
                    end else begin
                        if (lvl_q) cand_q <= 1'b1;
                        else if (id_q == dst_best_q) rdst_q <= 1'b1;
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (st != ST_IDLE);
        cmd_ready = !busy;
        mem_rd_en = (st == ST_SRC_RD) || (st == ST_DST_RD);
        mem_wr_en = (st == ST_SRC_WR) || (st == ST_DST_WR);
        src_side  = (st == ST_SRC_RD) || (st == ST_SRC_WR);
        mem_addr  = (src_side ? src_base_q : dst_base_q) + ADDR_W'(idx);
        mem_wdata = wbyte_q;
    end

    assign cand_valid = cand_q;
    assign cand_id    = id_q;
    assign rescan_src = rsrc_q;
    assign rescan_dst = rdst_q;

    // R12
    rw_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));

    // R12
    rmw_order_chk: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> ($past(mem_rd_en, 2) || $past(mem_wr_en)));

    // R3
    wr_changes_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DST_WR && !walk) |-> (mem_wdata != $past(mem_rdata)));

    // R11
    busy_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(cmd_valid && cmd_ready));

    // R4
    cand_after_wr_chk: assert property (@(posedge clk) disable iff (rst)
        cand_valid |-> ($past(mem_wr_en) && $past(mem_wdata[cand_id[2:0]])));

endmodule

// File: rtl/pend_table_engine.sv
module pend_table_engine
    import pend_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int ID_W     = 16,
    parameter int IDB_W    = 5,
    parameter int FIRST_ID = 8192
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_op,
    input  logic [ID_W-1:0]   cmd_id,
    input  logic              cmd_level,
    input  logic              src_en,
    input  logic [IDB_W-1:0]  src_idbits,
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ID_W-1:0]   src_best,
    input  logic              dst_en,
    input  logic [IDB_W-1:0]  dst_idbits,
    input  logic [ADDR_W-1:0] dst_base,
    input  logic [ID_W-1:0]   dst_best,
    output logic              busy,
    output logic              mem_rd_en,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              cand_valid,
    output logic [ID_W-1:0]   cand_id,
    output logic              rescan_src,
    output logic              rescan_dst
);
    localparam int BYTE_W = ID_W - 3;

    pend_op_e          op;
    pend_go_e          go;
    logic [BYTE_W-1:0] last_idx;

    assign op = pend_op_e'(cmd_op);

    pend_cmd_gate #(
        .ID_W(ID_W), .IDB_W(IDB_W), .FIRST_ID(FIRST_ID)
    ) u_gate (
        .op(op), .id(cmd_id),
        .src_en(src_en), .src_idbits(src_idbits),
        .dst_en(dst_en), .dst_idbits(dst_idbits),
        .go(go), .last_idx(last_idx)
    );

    pend_rmw_seq #(
        .ADDR_W(ADDR_W), .ID_W(ID_W), .FIRST_ID(FIRST_ID)
    ) u_seq (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .op(op), .id(cmd_id), .level(cmd_level),
        .go(go), .last_idx(last_idx),
        .src_base(src_base), .src_best(src_best),
        .dst_base(dst_base), .dst_best(dst_best),
        .busy(busy),
        .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cand_valid(cand_valid), .cand_id(cand_id),
        .rescan_src(rescan_src), .rescan_dst(rescan_dst)
    );

endmodule

// File: tb/test_pend_table_engine.sv
module test_pend_table_engine;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int ID_W   = 16;
    localparam int IDB_W  = 5;
    localparam int MEM_N  = 4096;

    localparam int K_WR = 0, K_CAND = 1, K_RS = 2, K_RD = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [1:0] cmd_op = '0;
    logic [ID_W-1:0] cmd_id = '0;
    logic cmd_level = 1'b0;
    logic s_en = 1'b1, d_en = 1'b1;
    logic [IDB_W-1:0] s_idb = 5'd13, d_idb = 5'd13;
    logic [ADDR_W-1:0] s_base = 32'd0, d_base = 32'd2048;
    logic [ID_W-1:0] s_best = '0, d_best = '0;
    logic busy, mem_rd_en, mem_wr_en, cand_valid, rescan_src, rescan_dst;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_wdata;
    logic [7:0] mem_rdata = 8'd0;
    logic [ID_W-1:0] cand_id;

    always #(CLK_PERIOD/2) clk = ~clk;

    pend_table_engine i_pend_table_engine (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_id(cmd_id), .cmd_level(cmd_level),
        .src_en(s_en), .src_idbits(s_idb), .src_base(s_base), .src_best(s_best),
        .dst_en(d_en), .dst_idbits(d_idb), .dst_base(d_base), .dst_best(d_best),
        .busy(busy), .mem_rd_en(mem_rd_en), .mem_wr_en(mem_wr_en),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .cand_valid(cand_valid), .cand_id(cand_id),
        .rescan_src(rescan_src), .rescan_dst(rescan_dst)
    );

    logic [7:0] ram [MEM_N];
    logic [7:0] shadow [MEM_N];
    int rd_cnt = 0;
    int checks = 0;
    int fails  = 0;

    typedef struct {
        int kind;
        int addr;
        int data;
    } ev_t;
    ev_t   exp_q[$];
    string tag_q[$];

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= ram[mem_addr[11:0]];
        if (mem_wr_en) ram[mem_addr[11:0]] <= mem_wdata;
    end

    task automatic check(input bit ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic observe(input int kind, input int addr, input int data);
        ev_t e;
        string t;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R12 unexpected event kind %0d addr %0d data %0d: actual event, expected none", kind, addr, data);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (e.kind != kind || e.addr != addr || e.data != data) begin
                fails++;
                $display("FAIL %s event: actual kind %0d addr %0d data %0d, expected kind %0d addr %0d data %0d",
                         t, kind, addr, data, e.kind, e.addr, e.data);
            end
        end
    endtask

    // monitor: pops the scoreboard as the design produces results
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_rd_en) rd_cnt++;
            if (mem_wr_en) observe(K_WR, int'(mem_addr), int'(mem_wdata));
            if (cand_valid) observe(K_CAND, int'(cand_id), 0);
            if (rescan_src) observe(K_RS, 0, 0);
            if (rescan_dst) observe(K_RD, 0, 0);
        end
    end

    function automatic int effw(input int idb);
        return (idb > ID_W - 1) ? ID_W - 1 : idb;
    endfunction

    task automatic push(input int kind, input int addr, input int data, input string tag);
        ev_t e;
        e.kind = kind; e.addr = addr; e.data = data;
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // destination set/clear model (R3, R4, R5)
    task automatic model_dst(input int id, input bit lvl, input string tag, inout int nrd);
        int a;
        logic [7:0] b;
        a = int'(d_base) + id / 8;
        b = shadow[a];
        nrd++;
        if (b[id % 8] != lvl) begin
            b[id % 8] = lvl;
            shadow[a] = b;
            push(K_WR, a, int'(b), tag);
            if (lvl) push(K_CAND, id, 0, tag);
            else if (id == int'(d_best)) push(K_RD, 0, 0, tag);
        end
    endtask

    task automatic do_cmd(input int op, input int id, input bit lvl, input string tag);
        int nrd = 0;
        int rd0, w, wd;
        int guard;
        bit same;
        wd = effw(int'(d_idb));
        w  = effw(int'(s_idb)) < wd ? effw(int'(s_idb)) : wd;
        if (op == 0) begin
            if (d_en && id >= 8192 && (id >> (wd + 1)) == 0) model_dst(id, lvl, tag, nrd);
        end else if (op == 1) begin
            if (s_en && d_en && (id >> (w + 1)) == 0) begin
                int a;
                logic [7:0] b;
                a = int'(s_base) + id / 8;
                b = shadow[a];
                nrd++;
                if (b[id % 8]) begin
                    b[id % 8] = 1'b0;
                    shadow[a] = b;
                    push(K_WR, a, int'(b), tag);
                    if (id == int'(s_best)) push(K_RS, 0, 0, tag);
                    model_dst(id, 1'b1, tag, nrd);
                end
            end
        end else if (op == 2) begin
            if (s_en && d_en) begin
                int nb;
                nb = (1 << (w + 1)) / 8;
                for (int i = 1024; i < nb; i++) begin
                    int sa, da;
                    sa = int'(s_base) + i;
                    da = int'(d_base) + i;
                    nrd++;
                    if (shadow[sa] != 8'd0) begin
                        nrd++;
                        shadow[da] = shadow[da] | shadow[sa];
                        push(K_WR, da, int'(shadow[da]), tag);
                        push(K_WR, sa, 0, tag);
                        shadow[sa] = 8'd0;
                    end
                end
                push(K_RS, 0, 0, tag);
                push(K_RD, 0, 0, tag);
            end
        end
        rd0 = rd_cnt;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_id = ID_W'(id); cmd_level = lvl;
        check(cmd_ready === 1'b1, "R11", "ready while idle", int'(cmd_ready), 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        check(busy === (nrd > 0), tag, "busy after accept (R11)", int'(busy), int'(nrd > 0));
        guard = 0;
        while (busy && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        @(negedge clk);
        check(exp_q.size() == 0, tag, "events left over", exp_q.size(), 0);
        exp_q.delete();
        tag_q.delete();
        check(rd_cnt - rd0 == nrd, tag, "read count (R12)", rd_cnt - rd0, nrd);
        same = 1'b1;
        for (int i = 0; i < MEM_N; i++) if (ram[i] !== shadow[i]) same = 1'b0;
        check(same, tag, "memory image", int'(same), 1);
    endtask

    task automatic preload(input int a, input logic [7:0] v);
        ram[a] = v;
        shadow[a] = v;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R11 watchdog expired: actual hung, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_N; i++) begin
            ram[i] = 8'd0;
            shadow[i] = 8'd0;
        end
        repeat (3) @(negedge clk);
        // R1 reset state
        check(cmd_ready === 1'b1 && busy === 1'b0, "R1", "ready/busy", int'({cmd_ready, busy}), 2);
        check(!mem_rd_en && !mem_wr_en && !cand_valid && !rescan_src && !rescan_dst, "R1", "quiet outputs",
              int'({mem_rd_en, mem_wr_en, cand_valid, rescan_src, rescan_dst}), 0);
        rst = 1'b0;
        @(negedge clk);

        // R3 R4: set an ID, then set it again (no write)
        do_cmd(0, 8200, 1'b1, "R4");
        do_cmd(0, 8200, 1'b1, "R3");
        // R5: clear the best ID, then clear a non-best ID
        d_best = 16'd8200;
        do_cmd(0, 8200, 1'b0, "R5");
        do_cmd(0, 8201, 1'b1, "R4");
        do_cmd(0, 8201, 1'b0, "R5");
        preload(2048 + 1030, 8'h5A);
        do_cmd(0, 8245, 1'b0, "R3");
        // R2 ignored cases
        do_cmd(0, 100, 1'b1, "R2");
        do_cmd(0, 16384, 1'b1, "R2");
        d_en = 1'b0;
        do_cmd(0, 8300, 1'b1, "R2");
        d_en = 1'b1;
        // R2 clamp of a large width field
        d_base = 32'd0; d_idb = 5'd20;
        do_cmd(0, 30000, 1'b1, "R2");
        d_base = 32'd2048; d_idb = 5'd13;
        // R11 reserved opcode
        do_cmd(3, 8400, 1'b1, "R11");

        // R8 single move: not pending, then pending and best, then already pending on dst
        do_cmd(1, 9000, 1'b0, "R8");
        preload(9000 / 8, 8'h03);
        s_best = 16'd9000;
        do_cmd(1, 9000, 1'b0, "R8");
        preload(9001 / 8, 8'h02 | ram[9001 / 8]);
        do_cmd(1, 9001, 1'b0, "R8");
        preload(9001 / 8, 8'h02 | ram[9001 / 8]);
        s_best = 16'd1;
        do_cmd(1, 9001, 1'b0, "R8");
        // R6 disabled sides
        preload(9100 / 8, 8'hFF);
        s_en = 1'b0;
        do_cmd(1, 9100, 1'b0, "R6");
        do_cmd(2, 0, 1'b0, "R6");
        s_en = 1'b1; d_en = 1'b0;
        do_cmd(1, 9100, 1'b0, "R6");
        d_en = 1'b1;
        // R7 width is the smaller side
        d_idb = 5'd14;
        preload(20000 / 8 - 2048, 8'h00);
        do_cmd(1, 16500, 1'b0, "R7");
        d_idb = 5'd13;

        // R9 R10 move-all merge
        preload(1030, 8'h0F);
        preload(1500, 8'hA5);
        preload(2047, 8'h80);
        preload(2048 + 2047, 8'h01);
        do_cmd(2, 0, 1'b0, "R9");
        // R10 empty range
        s_idb = 5'd12;
        do_cmd(2, 0, 1'b0, "R10");
        s_idb = 5'd13;

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule